// File: doc/BRIEF.md
# MSI Interrupt Remapping Unit

This block sits in the inbound interrupt path of an I/O translation unit. It takes one message-signalled interrupt write at a time: a 64-bit address, 32-bit data and the 16-bit ID of the requester. Using the requester's 256-bit device table entry, it decides whether the message passes through unchanged, is rebuilt from a 32-bit remap table entry, or is refused with a status code. The device table entry comes from a lookup port. The remap table entry is read over a plain request/acknowledge memory port.

The handling depends on the delivery mode carried in data bits [10:8]. Fixed and arbitrated interrupts follow a 2-bit per-device control field and, when that field selects remapping, a table lookup. NMI, INIT and external interrupts are forwarded only when the device grants them a pass bit. SMI and the unused encodings are refused. Each request ends with a single-cycle completion pulse that carries the status, the output address and the output data.

Top module: `msi_remap`

## Requirements
- R1: After reset, `reqReady` is 1 and `respDone` is 0.
- R2: When `devTabEmpty` is 1 at acceptance, the message completes with status 0 and unchanged address and data, and `dteReq` is never raised.
- R3: A requester ID equal to parameter INVALID_ID (default 16'hFFFF) is looked up as SUBST_ID (default 16'h00A0). Any other ID is presented on `dteId` as given. `dteReq` stays high until `dteAck`.
- R4: When bit 0 of DTE word 2 (`dteEntry[128]`) is 0, the message completes with status 0 and unchanged address and data.
- R5: When remapping is enabled and address bits [63:32] are non-zero, status is 1.
- R6: The delivery mode is data[10:8], with 0 fixed, 1 arbitrated, 4 NMI, 5 INIT and 7 external. Mode 2 (SMI) and modes 3 and 6 give status 1.
- R7: For fixed or arbitrated messages, DTE word 2 bits [61:60] select the action: 0 gives status 3, 1 passes the message unchanged with status 0, 2 remaps, and 3 gives status 1.
- R8: A remap reads the 32-bit word at address (DTE word 2 bits [50:6], kept in place with the low 6 bits zero) + data[10:0]*4. `memReq` and `memAddr` hold until `memAck`. If `memErr` is set with `memAck`, status is 2.
- R9: Entry bit 0 (valid) equal to 0 gives status 3. Otherwise entry bit 7 (guest) equal to 1 gives status 1. Otherwise an entry type in bits [4:2] greater than 1 gives status 1.
- R10: A good entry produces address 32'hFEE00000 with destination (entry[15:8]) in bits [19:12], hint (entry[5]) in bit 3 and destination mode (entry[6]) in bit 2, with bits [63:32] zero. It produces data with the vector (entry[23:16]) in bits [7:0] and the type in bits [10:8], and status 0.
- R11: NMI, INIT and external messages pass unchanged with status 0 only when DTE word 3 bit 58, 56 or 57 respectively is set. Otherwise status is 1.
- R12: For NMI, INIT and external messages, address bit 2 equal to 1 gives status 1.
- R13: `respDone` lasts one cycle and is never high together with `reqReady`. When status is non-zero, `respAddr` and `respData` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Unit idle, request accepted |
| reqAddr | input | 64 | MSI address |
| reqData | input | 32 | MSI data |
| reqSrcId | input | 16 | Requester ID |
| devTabEmpty | input | 1 | Device table has no entries |
| dteReq | output | 1 | Device entry lookup request |
| dteId | output | 16 | Device ID to look up |
| dteAck | input | 1 | Lookup response valid |
| dteEntry | input | 256 | Device entry, word n at bits [64n+63:64n] |
| memReq | output | 1 | Remap entry read request |
| memAddr | output | 64 | Remap entry byte address |
| memAck | input | 1 | Read response valid |
| memErr | input | 1 | Read failed |
| memRdata | input | 32 | Remap entry |
| respDone | output | 1 | Completion pulse |
| respStatus | output | 2 | 0 ok, 1 error, 2 fetch failure, 3 target abort |
| respAddr | output | 64 | Output MSI address |
| respData | output | 32 | Output MSI data |

## Verification
Random messages draw every delivery mode and every control field value, with random pass bits and a random remap-enable bit. Their addresses are sometimes given a non-zero upper half or destination-mode bit. This separates the three routing paths and the order in which the checks take effect. Random remap entries mix valid, guest and type faults with good entries, which tells the abort, error and rebuild outcomes apart. Directed cases cover the empty table, the substituted requester ID, a failed entry fetch and the entry offset at index 0 and 2047.

// File: rtl/msi_remap_pkg.sv
package msi_remap_pkg;
  typedef enum logic [1:0] {
    ST_OK    = 2'd0,
    ST_ERR   = 2'd1,
    ST_FETCH = 2'd2,
    ST_ABORT = 2'd3
  } stat_e;

  typedef enum logic [2:0] {
    ACT_PASS, ACT_REMAP, ACT_FETCH, ACT_ERR, ACT_ABORT
  } act_e;

  typedef struct packed {
    logic  capReq;
    logic  capDte;
    logic  capEnt;
    logic  outPass;
    logic  outRemap;
    logic  setStat;
    stat_e stat;
  } strobe_t;

  localparam int REMAP_EN_BIT = 0;
  localparam int CTL_LO       = 60;
  localparam int PB_INIT      = 56;
  localparam int PB_EXT       = 57;
  localparam int PB_NMI       = 58;
  localparam logic [2:0] DM_FIXED = 3'd0;
  localparam logic [2:0] DM_ARB   = 3'd1;
  localparam logic [2:0] DM_NMI   = 3'd4;
  localparam logic [2:0] DM_INIT  = 3'd5;
  localparam logic [2:0] DM_EXT   = 3'd7;
endpackage

// File: rtl/msi_remap_ctrl.sv
module msi_remap_ctrl
  import msi_remap_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    reqValid,
  input  logic    devTabEmpty,
  input  logic    dteAck,
  input  logic    memAck,
  input  logic    memErr,
  input  act_e    checkAct,
  input  act_e    decodeAct,
  output logic    reqReady,
  output logic    dteReq,
  output logic    memReq,
  output logic    respDone,
  output strobe_t strb
);
  typedef enum logic [2:0] {S_IDLE, S_DTE, S_CHECK, S_FETCH, S_DECODE, S_RESP} state_e;
  state_e state, nextState;

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    strb      = '0;
    reqReady  = (state == S_IDLE);
    dteReq    = (state == S_DTE);
    memReq    = (state == S_FETCH);
    respDone  = (state == S_RESP);
    case (state)
      S_IDLE: if (reqValid) begin
        strb.capReq = 1'b1;
        nextState   = devTabEmpty ? S_CHECK : S_DTE;
      end
      S_DTE: if (dteAck) begin
        strb.capDte = 1'b1;
        nextState   = S_CHECK;
      end
      S_CHECK: begin
        nextState    = S_RESP;
        strb.setStat = 1'b1;
        case (checkAct)
          ACT_PASS:  begin strb.outPass = 1'b1; strb.stat = ST_OK; end
          ACT_FETCH: begin strb.setStat = 1'b0; nextState = S_FETCH; end
          ACT_ABORT: strb.stat = ST_ABORT;
          default:   strb.stat = ST_ERR;
        endcase
      end
      S_FETCH: if (memAck) begin
        if (memErr) begin
          strb.setStat = 1'b1;
          strb.stat    = ST_FETCH;
          nextState    = S_RESP;
        end else begin
          strb.capEnt = 1'b1;
          nextState   = S_DECODE;
        end
      end
      S_DECODE: begin
        nextState    = S_RESP;
        strb.setStat = 1'b1;
        case (decodeAct)
          ACT_REMAP: begin strb.outRemap = 1'b1; strb.stat = ST_OK; end
          ACT_ABORT: strb.stat = ST_ABORT;
          default:   strb.stat = ST_ERR;
        endcase
      end
      default: nextState = S_IDLE;
    endcase
  end

  assert_done_pulse_R13: assert property (@(posedge clk) disable iff (!rstN)
    respDone |=> !respDone);
  assert_ready_done_excl_R13: assert property (@(posedge clk) disable iff (!rstN)
    !(reqReady && respDone));
  assert_dte_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    (dteReq && !dteAck) |=> dteReq);
endmodule

// File: rtl/msi_remap_dp.sv
module msi_remap_dp
  import msi_remap_pkg::*;
#(
  parameter logic [15:0] SUBST_ID   = 16'h00A0,
  parameter logic [15:0] INVALID_ID = 16'hFFFF
) (
  input  logic          clk,
  input  logic          rstN,
  input  strobe_t       strb,
  input  logic [63:0]   reqAddr,
  input  logic [31:0]   reqData,
  input  logic [15:0]   reqSrcId,
  input  logic          devTabEmpty,
  input  logic [255:0]  dteEntry,
  input  logic [31:0]   memRdata,
  output act_e          checkAct,
  output act_e          decodeAct,
  output logic [15:0]   dteId,
  output logic [63:0]   memAddr,
  output logic [63:0]   respAddr,
  output logic [31:0]   respData,
  output logic [1:0]    respStatus
);
  logic [63:0] addrQ, dte2Q, dte3Q, outAddr;
  logic [31:0] dataQ, entQ, outData;
  logic [15:0] idQ;
  logic        emptyQ;
  stat_e       statQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ <= '0; dataQ <= '0; idQ <= '0; emptyQ <= 1'b0;
      dte2Q <= '0; dte3Q <= '0; entQ <= '0;
      outAddr <= '0; outData <= '0; statQ <= ST_OK;
    end else begin
      if (strb.capReq) begin
        addrQ   <= reqAddr;
        dataQ   <= reqData;
        idQ     <= (reqSrcId == INVALID_ID) ? SUBST_ID : reqSrcId;
        emptyQ  <= devTabEmpty;
        outAddr <= '0;
        outData <= '0;
        statQ   <= ST_OK;
      end
      if (strb.capDte) begin
        dte2Q <= dteEntry[191:128];
        dte3Q <= dteEntry[255:192];
      end
      if (strb.capEnt) entQ <= memRdata;
      if (strb.outPass) begin
        outAddr <= addrQ;
        outData <= dataQ;
      end
      if (strb.outRemap) begin
        outAddr <= {32'h0, 12'hFEE, entQ[15:8], 8'h00, entQ[5], entQ[6], 2'b00};
        outData <= {21'h0, entQ[4:2], entQ[23:16]};
      end
      if (strb.setStat) statQ <= strb.stat;
    end
  end

  logic [2:0] dMode;
  logic [1:0] ctlField;
  logic       passBit;
  assign dMode    = dataQ[10:8];
  assign ctlField = dte2Q[CTL_LO +: 2];

  always_comb begin
    passBit = 1'b0;
    case (dMode)
      DM_NMI:  passBit = dte3Q[PB_NMI];
      DM_INIT: passBit = dte3Q[PB_INIT];
      DM_EXT:  passBit = dte3Q[PB_EXT];
      default: passBit = 1'b0;
    endcase
  end

  always_comb begin
    if (emptyQ || !dte2Q[REMAP_EN_BIT])      checkAct = ACT_PASS;
    else if (addrQ[63:32] != 32'h0)          checkAct = ACT_ERR;
    else if (dMode == DM_FIXED || dMode == DM_ARB) begin
      case (ctlField)
        2'd0:    checkAct = ACT_ABORT;
        2'd1:    checkAct = ACT_PASS;
        2'd2:    checkAct = ACT_FETCH;
        default: checkAct = ACT_ERR;
      endcase
    end else if (dMode == DM_NMI || dMode == DM_INIT || dMode == DM_EXT)
      checkAct = (addrQ[2] || !passBit) ? ACT_ERR : ACT_PASS;
    else                                     checkAct = ACT_ERR;
  end

  always_comb begin
    if (!entQ[0])             decodeAct = ACT_ABORT;
    else if (entQ[7])         decodeAct = ACT_ERR;
    else if (entQ[4:2] > 3'd1) decodeAct = ACT_ERR;
    else                      decodeAct = ACT_REMAP;
  end

  assign dteId      = idQ;
  assign memAddr    = {13'h0, dte2Q[50:6], 6'h0} + {51'h0, dataQ[10:0], 2'b00};
  assign respAddr   = outAddr;
  assign respData   = outData;
  assign respStatus = statQ;
endmodule

// File: rtl/msi_remap.sv
module msi_remap
  import msi_remap_pkg::*;
#(
  parameter logic [15:0] SUBST_ID   = 16'h00A0,
  parameter logic [15:0] INVALID_ID = 16'hFFFF
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         reqValid,
  output logic         reqReady,
  input  logic [63:0]  reqAddr,
  input  logic [31:0]  reqData,
  input  logic [15:0]  reqSrcId,
  input  logic         devTabEmpty,
  output logic         dteReq,
  output logic [15:0]  dteId,
  input  logic         dteAck,
  input  logic [255:0] dteEntry,
  output logic         memReq,
  output logic [63:0]  memAddr,
  input  logic         memAck,
  input  logic         memErr,
  input  logic [31:0]  memRdata,
  output logic         respDone,
  output logic [1:0]   respStatus,
  output logic [63:0]  respAddr,
  output logic [31:0]  respData
);
  strobe_t strb;
  act_e    checkAct, decodeAct;

  msi_remap_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .devTabEmpty(devTabEmpty),
    .dteAck(dteAck), .memAck(memAck), .memErr(memErr),
    .checkAct(checkAct), .decodeAct(decodeAct),
    .reqReady(reqReady), .dteReq(dteReq), .memReq(memReq),
    .respDone(respDone), .strb(strb)
  );

  msi_remap_dp #(.SUBST_ID(SUBST_ID), .INVALID_ID(INVALID_ID)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .reqAddr(reqAddr), .reqData(reqData),
    .reqSrcId(reqSrcId), .devTabEmpty(devTabEmpty), .dteEntry(dteEntry),
    .memRdata(memRdata), .checkAct(checkAct), .decodeAct(decodeAct),
    .dteId(dteId), .memAddr(memAddr), .respAddr(respAddr),
    .respData(respData), .respStatus(respStatus)
  );

  assert_mem_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck) |=> (memReq && $stable(memAddr)));
  assert_err_zero_R13: assert property (@(posedge clk) disable iff (!rstN)
    (respDone && respStatus != 2'd0) |-> (respAddr == 64'h0 && respData == 32'h0));
endmodule

// File: tb/msi_remap_tb.sv
module msi_remap_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rstN = 1'b0;
  logic reqValid = 1'b0, reqReady;
  logic [63:0] reqAddr = '0;
  logic [31:0] reqData = '0;
  logic [15:0] reqSrcId = '0;
  logic devTabEmpty = 1'b0;
  logic dteReq, dteAck = 1'b0;
  logic [15:0] dteId;
  logic [255:0] dteEntry = '0;
  logic memReq, memAck = 1'b0, memErr = 1'b0;
  logic [63:0] memAddr;
  logic [31:0] memRdata = '0;
  logic respDone;
  logic [1:0] respStatus;
  logic [63:0] respAddr;
  logic [31:0] respData;

  int nTests = 0, nFail = 0;
  logic [63:0] dte2, dte3;
  logic [31:0] entVal;
  logic fetchFail;
  logic sawDte, sawMem;
  logic [15:0] expId;
  logic [63:0] expMem;

  always #(CLK_PERIOD/2) clk = ~clk;

  msi_remap u_dut (.*);

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic void model(input logic [63:0] a, input logic [31:0] d, input logic emp,
                                output logic [1:0] st, output logic [63:0] oa, output logic [31:0] od);
    logic [2:0] dm;
    logic pb;
    dm = d[10:8];
    st = 2'd1; oa = '0; od = '0;
    if (emp || !dte2[0]) begin st = 0; oa = a; od = d; end
    else if (a[63:32] != 0) st = 1;
    else if (dm == 0 || dm == 1) begin
      case (dte2[61:60])
        2'd0: st = 3;
        2'd1: begin st = 0; oa = a; od = d; end
        2'd3: st = 1;
        default: begin
          if (fetchFail) st = 2;
          else if (!entVal[0]) st = 3;
          else if (entVal[7] || entVal[4:2] > 1) st = 1;
          else begin
            st = 0;
            oa = 64'hFEE00000 | (64'(entVal[15:8]) << 12) | (64'(entVal[5]) << 3) | (64'(entVal[6]) << 2);
            od = {21'h0, entVal[4:2], entVal[23:16]};
          end
        end
      endcase
    end else if (dm == 4 || dm == 5 || dm == 7) begin
      pb = (dm == 4) ? dte3[58] : (dm == 5) ? dte3[56] : dte3[57];
      if (a[2] || !pb) st = 1;
      else begin st = 0; oa = a; od = d; end
    end
  endfunction

  // responders for device lookup (R3) and entry fetch (R8)
  initial begin
    forever begin
      @(negedge clk);
      dteAck = 1'b0; memAck = 1'b0;
      if (dteReq) begin
        sawDte = 1'b1;
        chk("R3 dteId", 64'(dteId), 64'(expId));
        dteEntry = {dte3, dte2, 64'h0, 64'h0};
        dteAck = 1'b1;
      end
      if (memReq) begin
        sawMem = 1'b1;
        chk("R8 memAddr", memAddr, expMem);
        memRdata = entVal; memErr = fetchFail; memAck = 1'b1;
      end
    end
  end

  task automatic runOne(input string tag, input logic [63:0] a, input logic [31:0] d,
                        input logic [15:0] sid, input logic emp);
    logic [1:0] st; logic [63:0] oa; logic [31:0] od;
    int t = 0;
    model(a, d, emp, st, oa, od);
    expId  = (sid == 16'hFFFF) ? 16'h00A0 : sid;
    expMem = {13'h0, dte2[50:6], 6'h0} + 64'(d[10:0]) * 4;
    sawDte = 1'b0; sawMem = 1'b0;
    @(negedge clk);
    reqValid = 1'b1; reqAddr = a; reqData = d; reqSrcId = sid; devTabEmpty = emp;
    @(negedge clk);
    reqValid = 1'b0;
    while (!respDone && t < 50) begin @(negedge clk); t++; end
    if (t >= 50) begin nTests++; nFail++; $display("FAIL %s watchdog actual=timeout expected=done", tag); end
    chk({tag, " status"}, 64'(respStatus), 64'(st));
    chk({tag, " addr"}, respAddr, oa);
    chk({tag, " data"}, 64'(respData), 64'(od));
    if (emp) chk("R2 no lookup", 64'(sawDte), 64'd0);
    @(negedge clk);
    chk("R13 single pulse", 64'(respDone), 64'd0);
  endtask

  initial begin
    void'($urandom(32'd7519));
    dte2 = '0; dte3 = '0; entVal = '0; fetchFail = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 ready", 64'(reqReady), 64'd1);
    chk("R1 done", 64'(respDone), 64'd0);

    runOne("R2 empty", 64'hFEE0_1004, 32'h0000_0431, 16'h0012, 1'b1);
    dte2 = 64'h0; runOne("R4 disabled", 64'h1_FEE0_0000, 32'h0000_0200, 16'h0033, 1'b0);
    dte2 = 64'h1000_0000_0000_1001;
    dte3 = '0;
    runOne("R5 upper", 64'h1_FEE0_0000, 32'h0000_0030, 16'hFFFF, 1'b0);
    runOne("R6 SMI", 64'hFEE0_0000, 32'h0000_0200, 16'h0001, 1'b0);
    runOne("R6 reserved", 64'hFEE0_0000, 32'h0000_0600, 16'h0001, 1'b0);
    runOne("R7 pass", 64'hFEE0_0000, 32'h0000_0141, 16'h0002, 1'b0);
    dte2 = 64'h0000_0000_0000_0001; runOne("R7 abort", 64'hFEE0_0000, 32'h0000_0041, 16'h0002, 1'b0);
    dte2 = 64'h3000_0000_0000_0001; runOne("R7 reserved", 64'hFEE0_0000, 32'h0000_0041, 16'h0002, 1'b0);
    dte2 = 64'h2004_0000_1234_5681;
    entVal = 32'h0055_AB61;
    runOne("R10 remap idx0", 64'hFEE0_0000, 32'h0000_0000, 16'hFFFF, 1'b0);
    runOne("R8 remap idx2047", 64'hFEE0_0000, 32'h0000_07FF, 16'h0100, 1'b0);
    fetchFail = 1'b1; runOne("R8 fetch fail", 64'hFEE0_0000, 32'h0000_0010, 16'h0100, 1'b0);
    fetchFail = 1'b0;
    entVal = 32'h0055_AB60; runOne("R9 invalid", 64'hFEE0_0000, 32'h0000_0010, 16'h0100, 1'b0);
    entVal = 32'h0055_AB81; runOne("R9 guest", 64'hFEE0_0000, 32'h0000_0010, 16'h0100, 1'b0);
    entVal = 32'h0055_AB09; runOne("R9 type", 64'hFEE0_0000, 32'h0000_0010, 16'h0100, 1'b0);
    dte3 = 64'h0400_0000_0000_0000;
    runOne("R11 NMI pass", 64'hFEE0_0000, 32'h0000_0400, 16'h0005, 1'b0);
    runOne("R11 INIT denied", 64'hFEE0_0000, 32'h0000_0500, 16'h0005, 1'b0);
    runOne("R12 dest mode", 64'hFEE0_0004, 32'h0000_0400, 16'h0005, 1'b0);

    for (int i = 0; i < 300; i++) begin
      logic [63:0] a; logic [31:0] d;
      dte2 = {$urandom, $urandom};
      dte2[0] = ($urandom % 5) != 0;
      dte3 = {$urandom, $urandom};
      entVal = $urandom;
      entVal[0] = ($urandom % 4) != 0;
      entVal[7] = ($urandom % 5) == 0;
      entVal[4:2] = ($urandom % 3 == 0) ? 3'($urandom) : 3'($urandom % 2);
      fetchFail = ($urandom % 10) == 0;
      a = 64'hFEE0_0000 | 64'($urandom % 16'hFFFF) << 4 | 64'($urandom % 2) << 2;
      if ($urandom % 8 == 0) a[40] = 1'b1;
      d = $urandom;
      runOne("R6 random", a, d, ($urandom % 6 == 0) ? 16'hFFFF : 16'($urandom), 1'($urandom % 12 == 0));
    end

    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    nTests++; nFail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule